// File: doc/BRIEF.md
# Wired-AND Line Controller for a Two-Segment Bus Repeater

This block controls one line (clock or data) of a two-wire bus repeater. The repeater joins a source-side cable segment and a display-side segment so that they act as one wired-AND node. Comparators outside the block report each side's level as digital flags: pulled low, above the high-valid level, and, for the data line, below the re-entry level. From these flags the controller sets the enables for the cable pulldown, the cable strong pullup, the display pulldown and the line termination.

Any level change sets off a fixed six-phase cycle. The block drives the new level hard for a short assert window. A longer holdoff window then starts at the same change, and all level sensing is ignored while the bus settles. In the steady low phase the block holds low whichever side has already let go, and keeps it low until the other side lets go too. After the holdoff that follows a rise, it waits until both sides read high-valid before it returns to idle. The data variant can also leave that wait early when either side dips below the re-entry level.

The length of each window is a cycle count set by a parameter. One parameter chooses the clock or the data behaviour.

Top module: `wand_line_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the phase is idle (code 0) and all four enables are low.
- R2: The phase code (`phase_o`) steps only in this order: idle 0, fall 1, low-holdoff 2, low 3, rise 4, high-holdoff 5, then back to idle 0.
- R3: In idle, a low flag on either side, or on both sides in the same cycle, starts the fall phase. During fall the cable pulldown, display pulldown and termination are on for ASSERT_CYC cycles, and the cable pullup is off.
- R4: The holdoff lasts HOLD_CYC cycles, counted from the change of level. Once the fall or rise window ends, termination goes off. During low-holdoff both pulldowns stay on. Level flags that change inside the holdoff have no effect.
- R5: In the low phase, when exactly one side's low flag has cleared, that side is held low (source side by `cab_pd_en_o`, display side by `dsp_pd_en_o`) until the other side clears too. While both sides are still low, neither pulldown is on.
- R6: The rise phase starts only when both sides are released. During rise the cable pullup and termination are on for ASSERT_CYC cycles, and both pulldowns are off. The cable pullup and cable pulldown are never on together.
- R7: After the high-holdoff ends, the block returns to idle only when both high-valid flags are set. Until then it stays in high-holdoff, with one flag alone not enough.
- R8: With IS_DATA=1, a re-entry (dip) flag on either side after the high-holdoff ends also returns the block to idle. With IS_DATA=0 the dip flags have no effect.
- R9: Each level flag passes through a two-flop synchroniser. A change applied before a clock edge changes the phase after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_low_i | input | 1 | Source side below low trip |
| dsp_low_i | input | 1 | Display side below low trip |
| src_hi_i | input | 1 | Source side above high-valid level |
| dsp_hi_i | input | 1 | Display side above high-valid level |
| src_dip_i | input | 1 | Source side below re-entry level (data only) |
| dsp_dip_i | input | 1 | Display side below re-entry level (data only) |
| cab_pd_en_o | output | 1 | Cable-side pulldown enable |
| cab_pu_en_o | output | 1 | Cable-side strong pullup enable |
| dsp_pd_en_o | output | 1 | Display-side pulldown enable |
| term_en_o | output | 1 | Termination enable |
| phase_o | output | 3 | Current phase code |

## Verification
The bench builds two copies of the block, both with ASSERT_CYC=4 and HOLD_CYC=7. One copy has IS_DATA=1 and the other IS_DATA=0. Short windows let every phase boundary be reached within a few cycles, and the exact boundary cycle can be checked. Both copies are fed the same inputs, so the early dip exit shows up as a difference between the two variants in the same cycle. A glitch on the level flags placed fully inside the holdoff tests the input blanking.

// File: rtl/busext_pkg.sv
package busext_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_FALL  = 3'd1,
        PH_LHOLD = 3'd2,
        PH_LOW   = 3'd3,
        PH_RISE  = 3'd4,
        PH_HHOLD = 3'd5
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   hold_s;
        logic   hold_d;
        logic   cab_pd;
        logic   cab_pu;
        logic   dsp_pd;
        logic   term;
    } ctl_t;

    function automatic phase_e ph_succ(input phase_e p);
        case (p)
            PH_IDLE:  return PH_FALL;
            PH_FALL:  return PH_LHOLD;
            PH_LHOLD: return PH_LOW;
            PH_LOW:   return PH_RISE;
            PH_RISE:  return PH_HHOLD;
            default:  return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/busext_sync.sv
module busext_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            logic [W-1:0] src_d;
            if (i == 0) begin : g_first
                assign src_d = din;
            end else begin : g_next
                assign src_d = stg_q[i-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[i] <= '0;
                else        stg_q[i] <= src_d;
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/busext_timer.sv
module busext_timer #(
    parameter int HOLD_CYC = 250,
    localparam int CW = $clog2(HOLD_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)            cnt_d = '0;
        else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R4: the window count saturates at its last value and restarts from zero
    p_cnt_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt_q == '0);
endmodule

// File: rtl/wand_line_ctrl.sv
module wand_line_ctrl
    import busext_pkg::*;
#(
    parameter bit IS_DATA    = 1'b1,
    parameter int ASSERT_CYC = 175,
    parameter int HOLD_CYC   = 250,
    parameter int SYNC_STG   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_low_i,
    input  logic       dsp_low_i,
    input  logic       src_hi_i,
    input  logic       dsp_hi_i,
    input  logic       src_dip_i,
    input  logic       dsp_dip_i,
    output logic       cab_pd_en_o,
    output logic       cab_pu_en_o,
    output logic       dsp_pd_en_o,
    output logic       term_en_o,
    output logic [2:0] phase_o
);
    localparam int NFLAG = 6;
    localparam int CW    = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] ASRT_LAST = CW'(ASSERT_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

    logic [NFLAG-1:0] flag_raw, flag_s;
    logic s_low, d_low, s_hi, d_hi, s_dip, d_dip;
    logic [CW-1:0] tcnt;
    logic launch, asrt_end, hold_end, rel_s, rel_d, dip_exit;
    ctl_t cur_q, nxt_d;

    assign flag_raw = {src_low_i, dsp_low_i, src_hi_i, dsp_hi_i, src_dip_i, dsp_dip_i};

    busext_sync #(.W(NFLAG), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (flag_raw),
        .dout  (flag_s)
    );

    assign {s_low, d_low, s_hi, d_hi, s_dip, d_dip} = flag_s;

    busext_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (launch),
        .cnt_o   (tcnt)
    );

    generate
        if (IS_DATA) begin : g_data
            assign dip_exit = s_dip | d_dip;
        end else begin : g_clock
            assign dip_exit = 1'b0;
        end
    endgenerate

    assign asrt_end = (tcnt == ASRT_LAST);
    assign hold_end = (tcnt == HOLD_LAST);
    assign rel_s    = !s_low || cur_q.hold_s;
    assign rel_d    = !d_low || cur_q.hold_d;

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.ph)
            PH_IDLE: begin
                if (s_low || d_low) nxt_d.ph = PH_FALL;
            end
            PH_FALL: begin
                if (asrt_end) nxt_d.ph = PH_LHOLD;
            end
            PH_LHOLD: begin
                if (hold_end) begin
                    nxt_d.ph     = PH_LOW;
                    nxt_d.hold_s = !s_low && d_low;
                    nxt_d.hold_d = !d_low && s_low;
                end
            end
            PH_LOW: begin
                if (rel_s && rel_d) begin
                    nxt_d.ph     = PH_RISE;
                    nxt_d.hold_s = 1'b0;
                    nxt_d.hold_d = 1'b0;
                end else begin
                    nxt_d.hold_s = cur_q.hold_s | !s_low;
                    nxt_d.hold_d = cur_q.hold_d | !d_low;
                end
            end
            PH_RISE: begin
                if (asrt_end) nxt_d.ph = PH_HHOLD;
            end
            PH_HHOLD: begin
                if (hold_end && ((s_hi && d_hi) || dip_exit)) nxt_d.ph = PH_IDLE;
            end
            default: nxt_d.ph = PH_IDLE;
        endcase

        if (nxt_d.ph != PH_LOW) begin
            nxt_d.hold_s = 1'b0;
            nxt_d.hold_d = 1'b0;
        end

        nxt_d.cab_pd = 1'b0;
        nxt_d.cab_pu = 1'b0;
        nxt_d.dsp_pd = 1'b0;
        nxt_d.term   = 1'b0;
        case (nxt_d.ph)
            PH_FALL: begin
                nxt_d.cab_pd = 1'b1;
                nxt_d.dsp_pd = 1'b1;
                nxt_d.term   = 1'b1;
            end
            PH_LHOLD: begin
                nxt_d.cab_pd = 1'b1;
                nxt_d.dsp_pd = 1'b1;
            end
            PH_LOW: begin
                nxt_d.cab_pd = nxt_d.hold_s;
                nxt_d.dsp_pd = nxt_d.hold_d;
            end
            PH_RISE: begin
                nxt_d.cab_pu = 1'b1;
                nxt_d.term   = 1'b1;
            end
            default: ;
        endcase

        launch = (nxt_d.ph == PH_FALL && cur_q.ph != PH_FALL) ||
                 (nxt_d.ph == PH_RISE && cur_q.ph != PH_RISE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{ph: PH_IDLE, default: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign cab_pd_en_o = cur_q.cab_pd;
    assign cab_pu_en_o = cur_q.cab_pu;
    assign dsp_pd_en_o = cur_q.dsp_pd;
    assign term_en_o   = cur_q.term;
    assign phase_o     = cur_q.ph;

    // R2: phase advances only to its successor
    p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.ph != $past(cur_q.ph)) |-> (cur_q.ph == ph_succ($past(cur_q.ph))));
    // R6: pullup and pulldown on the cable never fight
    p_drv_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cab_pu_en_o && cab_pd_en_o));
    // R3: termination only inside the assert window of the timer
    p_term_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
        term_en_o |-> (tcnt <= ASRT_LAST));
    // R4: low-holdoff cannot be left before the window count ends
    p_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.ph == PH_LHOLD && tcnt != HOLD_LAST) |=> (cur_q.ph == PH_LHOLD));
    // R7: leaving high-holdoff needs both high flags or a data dip
    p_hi_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.ph == PH_IDLE && $past(cur_q.ph) == PH_HHOLD) |->
            ($past(s_hi && d_hi) || (IS_DATA && $past(s_dip || d_dip))));
endmodule

// File: tb/wand_line_ctrl_test.sv
module wand_line_ctrl_test;
    localparam int AC = 4;
    localparam int HC = 7;

    typedef struct packed {
        logic [5:0] stim;   // {s_low, d_low, s_hi, d_hi, s_dip, d_dip}
        logic [3:0] wt;     // negedges to wait after applying
        logic [2:0] ph;     // expected phase code
        logic [3:0] outs;   // expected {cab_pd, cab_pu, dsp_pd, term}
        logic [3:0] req;    // requirement number printed on failure
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{6'b100000, 4'd3, 3'd1, 4'b1011, 4'd3},  // R3 source pulls low
        '{6'b100000, 4'd4, 3'd2, 4'b1010, 4'd4},  // R4 low-holdoff
        '{6'b100000, 4'd3, 3'd3, 4'b0010, 4'd5},  // R5 display held
        '{6'b001100, 4'd3, 3'd4, 4'b0101, 4'd6},  // R6 rise
        '{6'b001100, 4'd4, 3'd5, 4'b0000, 4'd4},  // R4 high-holdoff
        '{6'b001100, 4'd3, 3'd0, 4'b0000, 4'd7},  // R7 back to idle
        '{6'b110000, 4'd3, 3'd1, 4'b1011, 4'd3},  // R3 both low together
        '{6'b110000, 4'd7, 3'd3, 4'b0000, 4'd5},  // R5 both low, no hold
        '{6'b010000, 4'd3, 3'd3, 4'b1000, 4'd5},  // R5 source held
        '{6'b000000, 4'd3, 3'd4, 4'b0101, 4'd6},  // R6 rise
        '{6'b000000, 4'd4, 3'd5, 4'b0000, 4'd4},  // R4
        '{6'b000000, 4'd3, 3'd5, 4'b0000, 4'd7},  // R7 waits, no high flags
        '{6'b001000, 4'd5, 3'd5, 4'b0000, 4'd7},  // R7 one flag not enough
        '{6'b001100, 4'd3, 3'd0, 4'b0000, 4'd7},  // R7
        '{6'b010000, 4'd3, 3'd1, 4'b1011, 4'd3},  // R3 display pulls low
        '{6'b010000, 4'd7, 3'd3, 4'b1000, 4'd5},  // R5 source held at entry
        '{6'b000000, 4'd3, 3'd4, 4'b0101, 4'd6},  // R6
        '{6'b001100, 4'd7, 3'd0, 4'b0000, 4'd2}   // R2 full cycle closed
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] stim = '0;
    logic cpd_a, cpu_a, dpd_a, trm_a, cpd_b, cpu_b, dpd_b, trm_b;
    logic [2:0] ph_a, ph_b;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    wand_line_ctrl #(.IS_DATA(1'b1), .ASSERT_CYC(AC), .HOLD_CYC(HC)) uut (
        .clk(clk), .rst_n(rst_n),
        .src_low_i(stim[5]), .dsp_low_i(stim[4]), .src_hi_i(stim[3]),
        .dsp_hi_i(stim[2]), .src_dip_i(stim[1]), .dsp_dip_i(stim[0]),
        .cab_pd_en_o(cpd_a), .cab_pu_en_o(cpu_a), .dsp_pd_en_o(dpd_a),
        .term_en_o(trm_a), .phase_o(ph_a)
    );

    wand_line_ctrl #(.IS_DATA(1'b0), .ASSERT_CYC(AC), .HOLD_CYC(HC)) uut_clk (
        .clk(clk), .rst_n(rst_n),
        .src_low_i(stim[5]), .dsp_low_i(stim[4]), .src_hi_i(stim[3]),
        .dsp_hi_i(stim[2]), .src_dip_i(stim[1]), .dsp_dip_i(stim[0]),
        .cab_pd_en_o(cpd_b), .cab_pu_en_o(cpu_b), .dsp_pd_en_o(dpd_b),
        .term_en_o(trm_b), .phase_o(ph_b)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got phase=%0d outs=%b, want phase=%0d outs=%b",
                     tag, act[6:4], act[3:0], exp[6:4], exp[3:0]);
        end
    endtask

    function automatic logic [6:0] obs_a();
        return {ph_a, cpd_a, cpu_a, dpd_a, trm_a};
    endfunction

    function automatic logic [6:0] obs_b();
        return {ph_b, cpd_b, cpu_b, dpd_b, trm_b};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(1);
        chk("R1 in reset data", obs_a(), 7'b000_0000);
        chk("R1 in reset clock", obs_b(), 7'b000_0000);
        stim = 6'b001100;
        tick(2);
        rst_n = 1'b1;
        tick(3);
        chk("R1 after reset", obs_a(), 7'b000_0000);

        for (int i = 0; i < NV; i++) begin
            stim = VECS[i].stim;
            tick(int'(VECS[i].wt));
            chk($sformatf("R%0d vector %0d", VECS[i].req, i), obs_a(),
                {VECS[i].ph, VECS[i].outs});
        end

        // R9: two-flop synchroniser plus state register
        stim = 6'b110000;
        tick(2);
        chk("R9 no change after two edges", obs_a(), 7'b000_0000);
        tick(1);
        chk("R9 fall after third edge", obs_a(), 7'b001_1011);

        // R4: glitch released inside holdoff is ignored
        tick(1);
        stim = 6'b000000;
        tick(2);
        stim = 6'b110000;
        tick(4);
        chk("R4 blank holds low phase", obs_a(), 7'b011_0000);
        tick(3);
        chk("R4 stays low", obs_a(), 7'b011_0000);

        // R8: dip exit only on the data variant
        stim = 6'b000000;
        tick(3);
        chk("R6 rise from both released", obs_a(), 7'b100_0101);
        tick(4);
        stim = 6'b000010;
        tick(2);
        chk("R8 dip blanked in holdoff", obs_a(), 7'b101_0000);
        tick(1);
        chk("R8 data exits on dip", obs_a(), 7'b000_0000);
        chk("R8 clock ignores dip", obs_b(), 7'b101_0000);
        stim = 6'b001100;
        tick(3);
        chk("R7 clock exits on high flags", obs_b(), 7'b000_0000);

        // R1: reset in the middle of a cycle
        stim = 6'b100000;
        tick(8);
        rst_n = 1'b0;
        tick(1);
        chk("R1 reset mid cycle", obs_a(), 7'b000_0000);
        stim = 6'b001100;
        rst_n = 1'b1;
        tick(4);
        chk("R1 idle after re-release", obs_a(), 7'b000_0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule